// File: doc/BRIEF.md
# Translation Cache with Page Permissions

This block is a small fully associative cache of address translations. Every lookup splits a 32-bit virtual address into a 20-bit virtual page number and a 12-bit offset inside a 4 KB page. It compares the page number against every valid entry at once and answers one cycle later. The answer is one of three: a hit carrying the physical address, a miss, or a protection fault. On a miss the block does not fetch anything. Software fills or repairs the cache through a configuration port and then retries the access.

Each entry holds a frame number, read and write permission bits, and two status bits that hardware keeps up to date. The touched bit records that the page has been used since software last cleared it, which lets software approximate least-recently-used replacement by epochs. The dirty bit records that the page has been written, so a clean page can be dropped without writeback. The configuration commands are install, invalidate by page, clear all touched bits, and flush everything. They take effect only while the processor is in privileged mode. A combinational peek port lets software read back any entry.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry reads back as invalid, `respValid` is 0 and `cfgPrivFault` is 0.
- R2: A lookup presented with `lookValid` is answered on the next cycle with `respValid` high. When the page number `lookAddr[31:12]` matches a valid entry and the permission allows the access, `respHit` is 1 and `respPaddr` is `{frame, lookAddr[11:0]}`.
- R3: When no valid entry matches the page number, `respMiss` is 1 and `respPaddr` is 0.
- R4: A read (`lookWrite`=0) to an entry without read permission, or a write (`lookWrite`=1) to an entry without write permission, gives `respProtFault`=1 and `respPaddr`=0 and leaves that entry's touched and dirty bits alone. A miss takes precedence over a protection fault, and at most one of hit, miss and fault is ever high.
- R5: Every permitted hit sets the touched bit of the matching entry.
- R6: A permitted write hit also sets the dirty bit of the matching entry. A read hit leaves the dirty bit unchanged.
- R7: Configuration commands act only when `privMode`=1. The `cfgOp` codes are 0 install, 1 invalidate by page, 2 clear touched and 3 flush all. A command given with `privMode`=0 changes no entry and raises `cfgPrivFault` on the next cycle.
- R8: An install writes the page number, frame and permissions into slot `cfgIndex`, with touched and dirty cleared. If `cfgVpn` is already held by a valid entry, that entry is overwritten instead and `cfgIndex` is ignored.
- R9: Clear touched resets every touched bit in one cycle. A permitted hit in the same cycle still leaves its own entry touched.
- R10: When a lookup and an install arrive in the same cycle, the lookup is answered from the contents before the install. The installed entry starts with touched and dirty at 0 even if the lookup hit it.
- R11: Invalidate by page clears the valid bit of the entry holding `cfgVpn`, and does nothing when no entry holds it. Flush all clears every valid bit.
- R12: The peek port shows the valid bit, page number, frame, read and write permissions, touched bit and dirty bit of entry `peekIndex` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privMode | input | 1 | 1 when the processor runs in privileged mode |
| lookValid | input | 1 | A lookup is presented this cycle |
| lookAddr | input | 32 | Virtual address to translate |
| lookWrite | input | 1 | 1 for a write access, 0 for a read |
| respValid | output | 1 | Lookup result is present |
| respHit | output | 1 | Translation succeeded |
| respMiss | output | 1 | No entry holds the page |
| respProtFault | output | 1 | Entry found but the access is not permitted |
| respPaddr | output | 32 | Physical address on a hit, otherwise 0 |
| cfgValid | input | 1 | A configuration command is presented |
| cfgOp | input | 2 | 0 install, 1 invalidate page, 2 clear touched, 3 flush all |
| cfgIndex | input | 4 | Slot used by an install of a new page |
| cfgVpn | input | 20 | Page number for install or invalidate |
| cfgPfn | input | 20 | Frame number for install |
| cfgRead | input | 1 | Read permission for install |
| cfgWrite | input | 1 | Write permission for install |
| cfgPrivFault | output | 1 | Previous command was refused in user mode |
| peekIndex | input | 4 | Entry selected for read-back |
| peekValid | output | 1 | Valid bit of the selected entry |
| peekVpn | output | 20 | Page number of the selected entry |
| peekPfn | output | 20 | Frame number of the selected entry |
| peekRead | output | 1 | Read permission of the selected entry |
| peekWrite | output | 1 | Write permission of the selected entry |
| peekTouched | output | 1 | Touched bit of the selected entry |
| peekDirty | output | 1 | Dirty bit of the selected entry |

## Verification
The bench fills all sixteen slots with every combination of the two permission bits and then issues reads and writes to each. This catches an inverted permission test, a fault that still sets touched, or a read that marks a page dirty. It installs a page that is already present into a different slot; a design that trusted `cfgIndex` would leave two valid entries and corrupt the match. It also drives a lookup alongside an install to the same page, and a hit alongside clear touched. A design that forwarded the new entry, kept stale status bits or let the clear win would return the wrong frame or the wrong touched bit. User-mode commands, including flush, are checked to leave every entry exactly as it was.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    OP_INSTALL   = 2'd0,
    OP_INVAL_VPN = 2'd1,
    OP_CLR_TOUCH = 2'd2,
    OP_FLUSH     = 2'd3
  } cfg_op_e;

  // strobes from control to the entry array
  typedef struct packed {
    logic installEn;
    logic invalEn;
    logic flushAll;
    logic clearTouched;
    logic hitUpd;
    logic hitDirty;
  } xlc_strobe_t;

endpackage

// File: rtl/xlc_datapath.sv
module xlc_datapath #(
  parameter  int ENTRIES = 16,
  parameter  int VPN_W   = 20,
  parameter  int PFN_W   = 20,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xlc_pkg::xlc_strobe_t    str,
  input  logic [IDX_W-1:0]        installIdx,
  input  logic [VPN_W-1:0]        lookVpn,
  input  logic [VPN_W-1:0]        cfgVpn,
  input  logic [PFN_W-1:0]        cfgPfn,
  input  logic                    cfgRead,
  input  logic                    cfgWrite,
  input  logic [IDX_W-1:0]        peekIndex,
  output logic [ENTRIES-1:0]      lookMatch,
  output logic [ENTRIES-1:0]      cfgMatch,
  output logic [PFN_W-1:0]        lookPfn,
  output logic                    lookRd,
  output logic                    lookWr,
  output logic                    peekValid,
  output logic [VPN_W-1:0]        peekVpn,
  output logic [PFN_W-1:0]        peekPfn,
  output logic                    peekRead,
  output logic                    peekWrite,
  output logic                    peekTouched,
  output logic                    peekDirty
);

  logic [ENTRIES-1:0] eValid, eRd, eWr, eTouched, eDirty;
  logic [VPN_W-1:0]   eVpn [ENTRIES];
  logic [PFN_W-1:0]   ePfn [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic installSel;
    assign installSel   = str.installEn && (installIdx == IDX_W'(i));
    assign lookMatch[i] = eValid[i] && (eVpn[i] == lookVpn);
    assign cfgMatch[i]  = eValid[i] && (eVpn[i] == cfgVpn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eValid[i]   <= 1'b0;
        eVpn[i]     <= '0;
        ePfn[i]     <= '0;
        eRd[i]      <= 1'b0;
        eWr[i]      <= 1'b0;
        eTouched[i] <= 1'b0;
        eDirty[i]   <= 1'b0;
      end else if (str.flushAll) begin
        eValid[i]   <= 1'b0;
        eTouched[i] <= 1'b0;
        eDirty[i]   <= 1'b0;
      end else if (installSel) begin
        eValid[i]   <= 1'b1;
        eVpn[i]     <= cfgVpn;
        ePfn[i]     <= cfgPfn;
        eRd[i]      <= cfgRead;
        eWr[i]      <= cfgWrite;
        eTouched[i] <= 1'b0;
        eDirty[i]   <= 1'b0;
      end else if (str.invalEn && cfgMatch[i]) begin
        eValid[i]   <= 1'b0;
      end else begin
        eTouched[i] <= (eTouched[i] && !str.clearTouched)
                       || (str.hitUpd && lookMatch[i]);
        eDirty[i]   <= eDirty[i] || (str.hitDirty && lookMatch[i]);
      end
    end
  end

  // one-hot select of the matching entry's fields
  always_comb begin
    lookPfn = '0;
    lookRd  = 1'b0;
    lookWr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lookPfn = lookPfn | ({PFN_W{lookMatch[i]}} & ePfn[i]);
      lookRd  = lookRd  | (lookMatch[i] & eRd[i]);
      lookWr  = lookWr  | (lookMatch[i] & eWr[i]);
    end
  end

  assign peekValid   = eValid[peekIndex];
  assign peekVpn     = eVpn[peekIndex];
  assign peekPfn     = ePfn[peekIndex];
  assign peekRead    = eRd[peekIndex];
  assign peekWrite   = eWr[peekIndex];
  assign peekTouched = eTouched[peekIndex];
  assign peekDirty   = eDirty[peekIndex];

endmodule

// File: rtl/xlc_ctrl.sv
module xlc_ctrl #(
  parameter  int ENTRIES   = 16,
  parameter  int PFN_W     = 20,
  parameter  int PAGE_BITS = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int PA_W      = PFN_W + PAGE_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  privMode,
  input  logic                  lookValid,
  input  logic                  lookWrite,
  input  logic [PAGE_BITS-1:0]  lookOffset,
  input  logic                  cfgValid,
  input  logic [1:0]            cfgOp,
  input  logic [IDX_W-1:0]      cfgIndex,
  input  logic [ENTRIES-1:0]    lookMatch,
  input  logic [ENTRIES-1:0]    cfgMatch,
  input  logic [PFN_W-1:0]      lookPfn,
  input  logic                  lookRd,
  input  logic                  lookWr,
  output xlc_pkg::xlc_strobe_t  str,
  output logic [IDX_W-1:0]      installIdx,
  output logic                  respValid,
  output logic                  respHit,
  output logic                  respMiss,
  output logic                  respProtFault,
  output logic [PA_W-1:0]       respPaddr,
  output logic                  cfgPrivFault
);
  import xlc_pkg::*;

  function automatic logic [IDX_W-1:0] ohToIdx(input logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vec[i]) idx = idx | IDX_W'(i);
    return idx;
  endfunction

  cfg_op_e op;
  logic    cfgOk, anyHit, permOk, goodHit;

  assign op      = cfg_op_e'(cfgOp);
  assign cfgOk   = cfgValid && privMode;
  assign anyHit  = |lookMatch;
  assign permOk  = lookWrite ? lookWr : lookRd;
  assign goodHit = lookValid && anyHit && permOk;

  always_comb begin
    str              = '0;
    str.installEn    = cfgOk && (op == OP_INSTALL);
    str.invalEn      = cfgOk && (op == OP_INVAL_VPN);
    str.clearTouched = cfgOk && (op == OP_CLR_TOUCH);
    str.flushAll     = cfgOk && (op == OP_FLUSH);
    str.hitUpd       = goodHit;
    str.hitDirty     = goodHit && lookWrite;
  end

  // a page already present keeps its slot
  assign installIdx = (|cfgMatch) ? ohToIdx(cfgMatch) : cfgIndex;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respMiss      <= 1'b0;
      respProtFault <= 1'b0;
      respPaddr     <= '0;
      cfgPrivFault  <= 1'b0;
    end else begin
      respValid     <= lookValid;
      respHit       <= goodHit;
      respMiss      <= lookValid && !anyHit;
      respProtFault <= lookValid && anyHit && !permOk;
      respPaddr     <= goodHit ? {lookPfn, lookOffset} : '0;
      cfgPrivFault  <= cfgValid && !privMode;
    end
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter  int ENTRIES   = 16,
  parameter  int VPN_W     = 20,
  parameter  int PFN_W     = 20,
  parameter  int PAGE_BITS = 12,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VA_W      = VPN_W + PAGE_BITS,
  localparam int PA_W      = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privMode,
  input  logic              lookValid,
  input  logic [VA_W-1:0]   lookAddr,
  input  logic              lookWrite,
  output logic              respValid,
  output logic              respHit,
  output logic              respMiss,
  output logic              respProtFault,
  output logic [PA_W-1:0]   respPaddr,
  input  logic              cfgValid,
  input  logic [1:0]        cfgOp,
  input  logic [IDX_W-1:0]  cfgIndex,
  input  logic [VPN_W-1:0]  cfgVpn,
  input  logic [PFN_W-1:0]  cfgPfn,
  input  logic              cfgRead,
  input  logic              cfgWrite,
  output logic              cfgPrivFault,
  input  logic [IDX_W-1:0]  peekIndex,
  output logic              peekValid,
  output logic [VPN_W-1:0]  peekVpn,
  output logic [PFN_W-1:0]  peekPfn,
  output logic              peekRead,
  output logic              peekWrite,
  output logic              peekTouched,
  output logic              peekDirty
);

  xlc_pkg::xlc_strobe_t str;
  logic [IDX_W-1:0]     installIdx;
  logic [ENTRIES-1:0]   lookMatch, cfgMatch;
  logic [PFN_W-1:0]     lookPfn;
  logic                 lookRd, lookWr;

  xlc_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dp (
    .clk, .rstN, .str, .installIdx,
    .lookVpn   (lookAddr[VA_W-1:PAGE_BITS]),
    .cfgVpn, .cfgPfn, .cfgRead, .cfgWrite, .peekIndex,
    .lookMatch, .cfgMatch, .lookPfn, .lookRd, .lookWr,
    .peekValid, .peekVpn, .peekPfn, .peekRead, .peekWrite,
    .peekTouched, .peekDirty
  );

  xlc_ctrl #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk, .rstN, .privMode, .lookValid, .lookWrite,
    .lookOffset (lookAddr[PAGE_BITS-1:0]),
    .cfgValid, .cfgOp, .cfgIndex,
    .lookMatch, .cfgMatch, .lookPfn, .lookRd, .lookWr,
    .str, .installIdx,
    .respValid, .respHit, .respMiss, .respProtFault, .respPaddr,
    .cfgPrivFault
  );

endmodule

// File: rtl/xlc_checker.sv
module xlc_checker #(
  parameter int IDX_W     = 4,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  parameter int PAGE_BITS = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      privMode,
  input logic                      lookValid,
  input logic [VPN_W+PAGE_BITS-1:0] lookAddr,
  input logic                      respValid,
  input logic                      respHit,
  input logic                      respMiss,
  input logic                      respProtFault,
  input logic [PFN_W+PAGE_BITS-1:0] respPaddr,
  input logic                      cfgValid,
  input logic [1:0]                cfgOp,
  input logic                      cfgPrivFault,
  input logic [IDX_W-1:0]          peekIndex,
  input logic                      peekValid,
  input logic [VPN_W-1:0]          peekVpn,
  input logic [PFN_W-1:0]          peekPfn,
  input logic                      peekRead,
  input logic                      peekWrite,
  input logic                      peekTouched,
  input logic                      peekDirty
);

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |=> respValid);

  p_hit_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |=> (respHit -> respPaddr[PAGE_BITS-1:0] == $past(lookAddr[PAGE_BITS-1:0])));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> respPaddr == '0);

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respHit, respMiss, respProtFault}) == 1);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respProtFault));

  p_user_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !privMode |=> cfgPrivFault);

  p_user_no_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !privMode && !lookValid) ##1 $stable(peekIndex) |->
      $stable(peekValid) && $stable(peekVpn) && $stable(peekPfn) &&
      $stable(peekRead) && $stable(peekWrite) && $stable(peekTouched) &&
      $stable(peekDirty));

  p_clear_touched_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && privMode && cfgOp == 2'd2 && !lookValid) |=> !peekTouched);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && privMode && cfgOp == 2'd3) |=> !peekValid);

endmodule

bind xlate_cache xlc_checker #(
  .IDX_W(IDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .privMode(privMode), .lookValid(lookValid),
  .lookAddr(lookAddr), .respValid(respValid), .respHit(respHit),
  .respMiss(respMiss), .respProtFault(respProtFault), .respPaddr(respPaddr),
  .cfgValid(cfgValid), .cfgOp(cfgOp), .cfgPrivFault(cfgPrivFault),
  .peekIndex(peekIndex), .peekValid(peekValid), .peekVpn(peekVpn),
  .peekPfn(peekPfn), .peekRead(peekRead), .peekWrite(peekWrite),
  .peekTouched(peekTouched), .peekDirty(peekDirty)
);

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privMode = 1'b1;
  logic        lookValid = 1'b0;
  logic [31:0] lookAddr = '0;
  logic        lookWrite = 1'b0;
  logic        respValid, respHit, respMiss, respProtFault;
  logic [31:0] respPaddr;
  logic        cfgValid = 1'b0;
  logic [1:0]  cfgOp = '0;
  logic [3:0]  cfgIndex = '0;
  logic [19:0] cfgVpn = '0, cfgPfn = '0;
  logic        cfgRead = 1'b0, cfgWrite = 1'b0;
  logic        cfgPrivFault;
  logic [3:0]  peekIndex = '0;
  logic        peekValid, peekRead, peekWrite, peekTouched, peekDirty;
  logic [19:0] peekVpn, peekPfn;

  int nTests = 0;
  int nFail  = 0;

  // reference model
  bit          mV [16];
  logic [19:0] mVpn [16];
  logic [19:0] mPfn [16];
  bit          mR [16], mW [16], mT [16], mD [16];

  always #2 clk = ~clk;

  xlate_cache u_dut (
    .clk, .rstN, .privMode, .lookValid, .lookAddr, .lookWrite,
    .respValid, .respHit, .respMiss, .respProtFault, .respPaddr,
    .cfgValid, .cfgOp, .cfgIndex, .cfgVpn, .cfgPfn, .cfgRead, .cfgWrite,
    .cfgPrivFault, .peekIndex, .peekValid, .peekVpn, .peekPfn,
    .peekRead, .peekWrite, .peekTouched, .peekDirty
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int findVpn(input logic [19:0] v);
    for (int i = 0; i < 16; i++)
      if (mV[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  // one cycle with an optional command and an optional lookup
  task automatic step(input bit cv, input logic [1:0] op, input logic [3:0] idx,
                      input logic [19:0] vpn, input logic [19:0] pfn,
                      input bit r, input bit w,
                      input bit lv, input logic [31:0] addr, input bit wr,
                      input bit priv, input string req);
    int  j, k;
    bit  eHit, eMiss, eProt;
    logic [31:0] ePa;
    bit  skip [16];
    @(negedge clk);
    privMode = priv;
    cfgValid = cv; cfgOp = op; cfgIndex = idx; cfgVpn = vpn; cfgPfn = pfn;
    cfgRead = r; cfgWrite = w;
    lookValid = lv; lookAddr = addr; lookWrite = wr;
    j = findVpn(addr[31:12]);
    eMiss = (j < 0);
    eProt = !eMiss && !(wr ? mW[j] : mR[j]);
    eHit  = !eMiss && !eProt;
    ePa   = eHit ? {mPfn[j], addr[11:0]} : 32'h0;
    @(posedge clk);
    #1;
    cfgValid = 1'b0; lookValid = 1'b0; privMode = 1'b1;
    if (lv) begin
      chk(respValid == 1'b1, req, "respValid", respValid, 1);
      chk(respHit == eHit, eHit ? "R2" : req, "respHit", respHit, eHit);
      chk(respMiss == eMiss, "R3", "respMiss", respMiss, eMiss);
      chk(respProtFault == eProt, "R4", "respProtFault", respProtFault, eProt);
      chk(respPaddr == ePa, req, "respPaddr", respPaddr, ePa);
    end else begin
      chk(respValid == 1'b0, req, "respValid idle", respValid, 0);
    end
    chk(cfgPrivFault == (cv && !priv), "R7", "cfgPrivFault", cfgPrivFault, cv && !priv);
    for (int i = 0; i < 16; i++) skip[i] = 1'b0;
    if (cv && priv) begin
      case (op)
        2'd0: begin
          k = findVpn(vpn);
          if (k < 0) k = int'(idx);
          mV[k] = 1; mVpn[k] = vpn; mPfn[k] = pfn; mR[k] = r; mW[k] = w;
          mT[k] = 0; mD[k] = 0; skip[k] = 1;
        end
        2'd1: begin
          k = findVpn(vpn);
          if (k >= 0) begin mV[k] = 0; skip[k] = 1; end
        end
        2'd2: for (int i = 0; i < 16; i++) mT[i] = 0;
        default: for (int i = 0; i < 16; i++) begin
          mV[i] = 0; mT[i] = 0; mD[i] = 0; skip[i] = 1;
        end
      endcase
    end
    if (lv && eHit && !skip[j]) begin
      mT[j] = 1;
      if (wr) mD[j] = 1;
    end
  endtask

  task automatic look(input logic [31:0] a, input bit wr, input string req);
    step(0, 2'd0, 4'd0, 20'h0, 20'h0, 0, 0, 1, a, wr, 1, req);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] idx, input logic [19:0] vpn,
                     input logic [19:0] pfn, input bit r, input bit w, input bit priv,
                     input string req);
    step(1, op, idx, vpn, pfn, r, w, 0, 32'h0, 0, priv, req);
  endtask

  // read back every entry through the peek port
  task automatic checkAll(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      peekIndex = 4'(i);
      #1;
      if (!mV[i])
        chk(peekValid == 1'b0, req, $sformatf("entry %0d valid", i), peekValid, 0);
      else
        chk({peekValid, peekVpn, peekPfn, peekRead, peekWrite, peekTouched, peekDirty}
            == {1'b1, mVpn[i], mPfn[i], mR[i], mW[i], mT[i], mD[i]},
            req, $sformatf("entry %0d (R12 fields)", i),
            {peekValid, peekVpn, peekPfn, peekRead, peekWrite, peekTouched, peekDirty},
            {1'b1, mVpn[i], mPfn[i], mR[i], mW[i], mT[i], mD[i]});
    end
  endtask

  function automatic logic [19:0] vpnOf(input int i);
    return 20'h10000 + 20'(i) * 20'h00123;
  endfunction

  function automatic logic [19:0] pfnOf(input int i);
    return 20'h80000 ^ (20'(i) * 20'h000F1);
  endfunction

  initial begin
    #(4 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mV[i] = 0; mVpn[i] = '0; mPfn[i] = '0; mR[i] = 0; mW[i] = 0; mT[i] = 0; mD[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    chk(cfgPrivFault == 1'b0, "R1", "cfgPrivFault after reset", cfgPrivFault, 0);
    checkAll("R1");

    // R8 fill all slots, permissions r = bit0, w = bit1 of slot
    for (int i = 0; i < 16; i++)
      cmd(2'd0, 4'(i), vpnOf(i), pfnOf(i), i[0], i[1], 1, "R8");
    checkAll("R8");

    // R2 R4 R5 R6 read then write to every page
    for (int i = 0; i < 16; i++) begin
      look({vpnOf(i), 12'(i * 55)}, 0, "R2 R4 R5");
      look({vpnOf(i), 12'hFFF - 12'(i)}, 1, "R2 R4 R6");
    end
    checkAll("R5 R6");

    // R3 misses
    for (int i = 0; i < 4; i++)
      look({20'hABC00 + 20'(i), 12'h123}, i[0], "R3");

    // R9 clear touched, then clear together with a hit
    cmd(2'd2, 4'd0, 20'h0, 20'h0, 0, 0, 1, "R9");
    checkAll("R9");
    look({vpnOf(1), 12'h010}, 0, "R5");
    step(1, 2'd2, 4'd0, 20'h0, 20'h0, 0, 0, 1, {vpnOf(3), 12'h020}, 0, 1, "R9");
    checkAll("R9");

    // R7 user-mode commands change nothing
    cmd(2'd0, 4'd5, 20'h55555, 20'h12345, 1, 1, 0, "R7");
    cmd(2'd3, 4'd0, 20'h0, 20'h0, 0, 0, 0, "R7");
    cmd(2'd1, 4'd0, vpnOf(7), 20'h0, 0, 0, 0, "R7");
    cmd(2'd2, 4'd0, 20'h0, 20'h0, 0, 0, 0, "R7");
    checkAll("R7");

    // R8 reinstall a present page into a different slot
    cmd(2'd0, 4'd9, vpnOf(3), 20'h0BEEF, 1, 0, 1, "R8");
    checkAll("R8");
    look({vpnOf(3), 12'h456}, 0, "R8");
    look({vpnOf(3), 12'h456}, 1, "R8");

    // R10 install and lookup of the same page in one cycle
    step(1, 2'd0, 4'd0, vpnOf(6), 20'h0CAFE, 1, 1, 1, {vpnOf(6), 12'h777}, 1, 1, "R10");
    checkAll("R10");
    look({vpnOf(6), 12'h777}, 0, "R10");

    // R11 invalidate one page, an absent page, then flush
    cmd(2'd1, 4'd0, vpnOf(2), 20'h0, 0, 0, 1, "R11");
    cmd(2'd1, 4'd0, 20'hFEDCB, 20'h0, 0, 0, 1, "R11");
    look({vpnOf(2), 12'h000}, 0, "R11");
    checkAll("R11");
    cmd(2'd3, 4'd0, 20'h0, 20'h0, 0, 0, 1, "R11");
    checkAll("R11");
    look({vpnOf(5), 12'h001}, 0, "R11");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule